// File: doc/BRIEF.md
# Burst Address and Cycle Controller

This block sits between a synchronous memory bus and a memory core. On every enabled clock edge it reads two active-low address strobes, three chip-select lines of mixed polarity, a burst-step request and a write indication. From these it decides whether the cycle opens a new access, steps an access already under way, pauses it, or drops the selection. The outcome is held in registers, and from those registers it drives the current word address, the access kind and a valid flag to the core.

A new access loads the external address. After that, while neither strobe is active, a low step request moves the two least significant address bits to the next beat of a four-beat group. The upper bits stay where they were loaded. The beat order is either a wrapping linear count or an XOR-interleaved pattern, chosen by a static mode pin. An active-low clock enable freezes the whole block when it is high.

Top module: `burst_addr_ctl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears its registers, so `addr_out`, `op_write` and `op_valid` all read 0 after that edge.
- R2: Each decision is taken at a rising edge and shows on the outputs straight after that edge. A cycle opens when `cs_main_n`=0, `cs_pos`=1 and `cs_neg_n`=0 and a strobe starts it. An open cycle loads `addr_in` into `addr_out` and sets `op_valid`=1.
- R3: A strobe that starts a cycle while any of the three selects is inactive is a deselect: `op_valid` and `op_write` go to 0. This covers `strobe_ctl_n`=0 with any select inactive, and `strobe_cpu_n`=0 with `cs_main_n`=0 but `cs_pos`=0 or `cs_neg_n`=1.
- R4: When `cs_main_n`=1, `strobe_cpu_n` has no effect. The cycle behaves exactly as it would with `strobe_cpu_n`=1.
- R5: A cycle started by `strobe_cpu_n`=0 (with `cs_main_n`=0) takes priority over `strobe_ctl_n` and always opens a read (`op_write`=0), whatever `wr_req` is.
- R6: A cycle started by `strobe_ctl_n`=0 while `strobe_cpu_n` is not in effect opens a write when `wr_req`=1 and a read when `wr_req`=0.
- R7: With no strobe in effect and `op_valid`=1, `addr_in` is ignored and `op_write` is kept. `step_n`=0 moves to the next beat. `step_n`=1 holds `addr_out`. Bits above bit 1 never change.
- R8: With `seq_xor`=0, beat k of a burst puts (s + k) mod 4 on `addr_out[1:0]`, where s is the loaded value of bits [1:0].
- R9: With `seq_xor`=1, beat k puts s XOR k on `addr_out[1:0]`. The beat count k restarts at 0 on every load.
- R10: When `clk_en_n`=1 at a rising edge, `addr_out`, `op_write` and `op_valid` hold their values.
- R11: While `op_valid`=0, cycles without a strobe in effect leave `op_valid`=0 and `addr_out` unchanged, whatever `step_n` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls the block |
| strobe_cpu_n | input | 1 | Read-only start strobe, active low, gated by `cs_main_n` |
| strobe_ctl_n | input | 1 | General start strobe, active low |
| cs_main_n | input | 1 | Main chip select, active low |
| cs_pos | input | 1 | Chip select, active high |
| cs_neg_n | input | 1 | Chip select, active low |
| step_n | input | 1 | Burst step request, active low |
| wr_req | input | 1 | Decoded write request for strobe-started cycles |
| seq_xor | input | 1 | Beat order: 1 interleaved, 0 linear |
| addr_in | input | AW | External word address |
| addr_out | output | AW | Current burst address to the core |
| op_write | output | 1 | Access kind: 1 write, 0 read |
| op_valid | output | 1 | Access in progress |

## Verification
If the stored start offset or beat count is wrong, the error shows on `addr_out[1:0]` on the very next stepped beat, and it repeats every four beats after that. If the valid or kind flag is wrong, `op_valid` or `op_write` is off in the cycle right after the edge that decided it. The bench therefore compares all three outputs after every edge. It sweeps every combination of selects, strobes, step, write request and stall from a live burst in both beat orders, and it follows each combination with a step cycle. That step cycle exposes any deselect that left state behind.

// File: rtl/burst_addr_ctl.sv
module burst_addr_ctl #(
  parameter int AW = 18,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en_n,
  input  logic          strobe_cpu_n,
  input  logic          strobe_ctl_n,
  input  logic          cs_main_n,
  input  logic          cs_pos,
  input  logic          cs_neg_n,
  input  logic          step_n,
  input  logic          wr_req,
  input  logic          seq_xor,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic          op_write,
  output logic          op_valid
);
  localparam int UW = AW - BW;

  logic [UW-1:0] upper_q;
  logic [BW-1:0] low_q, start_q, beat_q;
  logic          wr_q, valid_q;

  wire selected = !cs_main_n && cs_pos && !cs_neg_n;
  wire cpu_go   = !strobe_cpu_n && !cs_main_n;
  wire ctl_go   = !strobe_ctl_n && !cpu_go;
  wire start    = cpu_go || ctl_go;
  wire advance  = !start && valid_q && !step_n;

  wire [BW-1:0] beat_nx = beat_q + 1'b1;
  wire [BW-1:0] low_nx  = seq_xor ? (start_q ^ beat_nx) : (start_q + beat_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      low_q   <= '0;
      start_q <= '0;
      beat_q  <= '0;
      wr_q    <= 1'b0;
      valid_q <= 1'b0;
    end else if (!clk_en_n) begin
      if (start && selected) begin
        upper_q <= addr_in[AW-1:BW];
        low_q   <= addr_in[BW-1:0];
        start_q <= addr_in[BW-1:0];
        beat_q  <= '0;
        wr_q    <= ctl_go && wr_req;
        valid_q <= 1'b1;
      end else if (start) begin
        wr_q    <= 1'b0;
        valid_q <= 1'b0;
      end else if (advance) begin
        beat_q  <= beat_nx;
        low_q   <= low_nx;
      end
    end
  end

  assign addr_out = {upper_q, low_q};
  assign op_write = wr_q;
  assign op_valid = valid_q;
endmodule

// File: rtl/burst_addr_ctl_chk.sv
module burst_addr_ctl_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          strobe_cpu_n,
  input logic          strobe_ctl_n,
  input logic          cs_main_n,
  input logic          cs_pos,
  input logic          cs_neg_n,
  input logic          step_n,
  input logic [AW-1:0] addr_out,
  input logic          op_write,
  input logic          op_valid
);
  wire sel_ok = !cs_main_n && cs_pos && !cs_neg_n;
  wire no_strobe = strobe_ctl_n && (strobe_cpu_n || cs_main_n);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> !op_valid && !op_write && addr_out == '0); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(addr_out) && $stable(op_valid) && $stable(op_write)); // R10

  AST_CPU_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_n && !strobe_cpu_n && sel_ok |=> op_valid && !op_write); // R5

  AST_BAD_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_n && !strobe_ctl_n && !sel_ok |=> !op_valid && !op_write); // R3

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_n && no_strobe |=> $stable(addr_out[AW-1:2]) && $stable(op_write)); // R7

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_n && no_strobe && step_n |=> $stable(addr_out)); // R7

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_n && no_strobe && !op_valid |=> !op_valid && $stable(addr_out)); // R11
endmodule

bind burst_addr_ctl burst_addr_ctl_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_burst_addr_ctl.sv
module sim_burst_addr_ctl;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n, clk_en_n, strobe_cpu_n, strobe_ctl_n, cs_main_n, cs_pos, cs_neg_n;
  logic step_n, wr_req, seq_xor;
  logic [AW-1:0] addr_in, addr_out;
  logic op_write, op_valid;

  int checks = 0, fails = 0;
  bit done = 0;

  logic          e_valid, e_write;
  logic [AW-3:0] e_up;
  logic [1:0]    e_start, e_k;

  always #2 clk = ~clk;

  burst_addr_ctl #(.AW(AW)) u0 (.*);

  function automatic logic [AW-1:0] exp_addr();
    logic [1:0] lo;
    lo = seq_xor ? (e_start ^ e_k) : (e_start + e_k);
    return {e_up, lo};
  endfunction

  task automatic check(input string tag);
    checks++;
    if ({addr_out, op_write, op_valid} !== {exp_addr(), e_write, e_valid}) begin
      fails++;
      $display("FAIL %s: addr=%0h wr=%0b vld=%0b expected addr=%0h wr=%0b vld=%0b",
               tag, addr_out, op_write, op_valid, exp_addr(), e_write, e_valid);
    end
  endtask

  // drive at negedge, let one rising edge pass, compare at the next negedge
  task automatic cyc(input logic stl, cm, cp, cn, sp, sc, st, wr, input logic [AW-1:0] a);
    string tag;
    logic ok, cg, tg;
    clk_en_n = stl; cs_main_n = cm; cs_pos = cp; cs_neg_n = cn;
    strobe_cpu_n = sp; strobe_ctl_n = sc; step_n = st; wr_req = wr; addr_in = a;
    ok = !cm && cp && !cn;
    cg = !sp && !cm;
    tg = !sc && !cg;
    if (stl) tag = "R10";
    else if (cg || tg) begin
      if (ok) begin
        e_valid = 1; e_write = tg && wr; e_up = a[AW-1:2]; e_start = a[1:0]; e_k = 0;
        tag = cg ? "R5" : (!sp ? "R4 R2 R6" : "R2 R6");
      end else begin
        e_valid = 0; e_write = 0; tag = "R3";
      end
    end else if (!e_valid) tag = "R11";
    else if (!st) begin
      e_k = e_k + 1;
      tag = seq_xor ? "R7 R9" : "R7 R8";
    end else tag = !sp ? "R4 R7" : "R7";
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clk_en_n = 0; strobe_cpu_n = 1; strobe_ctl_n = 1; cs_main_n = 0;
    cs_pos = 1; cs_neg_n = 0; step_n = 1; wr_req = 0; seq_xor = 0; addr_in = '1;
    e_valid = 0; e_write = 0; e_up = '0; e_start = 0; e_k = 0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;

    // full four-beat bursts from every start offset, both orders, twice round
    for (int m = 0; m < 2; m++) begin
      seq_xor = m[0];
      for (int s = 0; s < 4; s++) begin
        cyc(0, 0, 1, 0, 1, 0, 1, s[0], AW'(s + 4 * (s + 3)));
        for (int b = 0; b < 8; b++) cyc(0, 0, 1, 0, 1, 1, b == 3, 0, '1);
      end
    end

    // every control combination from a live burst, then a step cycle
    for (int m = 0; m < 2; m++) begin
      seq_xor = m[0];
      for (int c = 0; c < 256; c++) begin
        logic [AW-1:0] ld;
        ld = AW'(c * 7 + 5);
        cyc(0, 0, 1, 0, 1, 0, 1, c[0], ld);
        cyc(0, 0, 1, 0, 1, 1, 0, 0, ~ld);
        cyc(c[7], c[6], c[5], c[4], c[3], c[2], c[1], c[0], AW'(c * 13 + 2));
        cyc(0, 0, 1, 0, 1, 1, 0, 1, ~ld);
        cyc(0, 1, 0, 1, 0, 1, 1, 1, ld);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule